// File: doc/BRIEF.md
# Interconnect Firewall Region Checker

This block sits beside an on-chip interconnect port and judges every access that crosses it. It holds a parameterised set of protection regions. Each region pairs a 32-bit match word (base, size, address-space tag and priority bit) with three 16-bit initiator masks: request-info, read and write. For each access presented on the access port, the block finds every region that covers the address and space, keeps the one with the highest priority level, and grants or denies the access from that region's masks.

Region 0 is a permanent catch-all at the lowest level. It has no decodable match word, so an access that no other region claims falls back to region 0's masks. A denied access is captured in an error log that holds the first offending address, initiator and direction until software clears it. Regions and the log are reached through a simple word-addressed register port with a combinational read path. Software is expected to write a region's masks before its match word, because the region starts decoding as soon as the match word is written.

Top module: `fw_region_guard`

## Requirements
- R1: After reset, every mask of every region is all ones, every match word reads 0, the error log is clear, dec_valid is 0, and any access is granted by region 0.
- R2: Region 0 covers every address and space at level 0. Writes to its match word are ignored, and the word reads back 0.
- R3: A region r>0 is enabled only when match-word bits 7:3 (size exponent S) are nonzero. It covers an address when the address bits at and above bit S+10 equal the same bits of the match word, and the match-word bits 2:0 equal the access space tag. The span is therefore 2^S KB.
- R4: Region 1 always has level 3. Every region r>=2 has level equal to match-word bit 9 plus one.
- R5: Among the covering regions, the highest level wins. On a level tie the higher index wins. dec_region reports the winning index.
- R6: An access is granted only when the winner's request-info mask bit at index acc_init is 1 and its read mask bit (acc_write=0) or write mask bit (acc_write=1) at that index is 1. Bit 1 is the CPU, bit 3 system DMA, bit 4 the USB OTG controller and bit 9 the USB host.
- R7: The decision appears on dec_valid, dec_allow and dec_region one clock after the access is presented. A register write affects only accesses presented in later cycles.
- R8: When a denied access arrives while the log flag is 0, the flag is set and the log captures the address, initiator and direction. Later denials do not overwrite the log while the flag stays set.
- R9: A write to the clear word with bit 0 at 1 empties the log. With bit 0 at 0 the write has no effect. If a denial arrives in the same cycle as a clear, the new denial is logged.
- R10: The register map uses word index r*4+f for region r, where f=0 is request-info, 1 is read, 2 is write and 3 is the match word. Masks occupy bits 15:0. The log sits at NREG*4 plus an offset: +0 is status (bit 0 flag, bit 1 logged direction, 1 meaning write), +1 is the address, +2 is the initiator and +3 is the clear word, which reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_space | input | 3 | Access address-space tag |
| acc_init | input | 4 | Initiator index into the masks |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| dec_valid | output | 1 | Decision valid |
| dec_allow | output | 1 | Access granted |
| dec_region | output | 3 | Winning region index |
| err_flag | output | 1 | Error log holds a denial |

## Verification
Directed patterns place overlapping windows on a shared base. These separate an index tie (the higher index must win) from a level difference (bit 9 promotion, and region 1's fixed top level). They also separate a window miss caused by the space tag from one caused by the address lying past 2^S KB. Random region programming with small, overlapping bases and random initiators, directions and sizes, including size 0, exercises the winner search against a bench model and distinguishes read-mask from write-mask and request-info faults. Log patterns pit a second denial against a held log, a clear written as 0 against one written as 1, and a clear against a denial in the same cycle.

// File: rtl/fw_guard_pkg.sv
package fw_guard_pkg;
    localparam int WORD_W   = 32;
    localparam int MASK_W   = 16;
    localparam int INIT_W   = $clog2(MASK_W);
    localparam int SPACE_W  = 3;
    localparam int LVL_W    = 2;
    localparam int SIZE_LSB = 3;
    localparam int SIZE_MSB = 7;
    localparam int SIZE_W   = SIZE_MSB - SIZE_LSB + 1;
    localparam int LVL_BIT  = 9;
    localparam int BASE_LSB = 10;
    localparam int KB_SHIFT = 10;
    localparam int SHAMT_W  = 6;
    localparam int TOP_LVL  = 3;

    typedef struct packed {
        logic [MASK_W-1:0] info;
        logic [MASK_W-1:0] rd;
        logic [MASK_W-1:0] wr;
        logic [WORD_W-1:0] amatch;
    } region_t;

    typedef enum logic [1:0] {
        FLD_INFO   = 2'd0,
        FLD_RD     = 2'd1,
        FLD_WR     = 2'd2,
        FLD_AMATCH = 2'd3
    } field_e;

    typedef enum logic [1:0] {
        LOGW_STATUS = 2'd0,
        LOGW_ADDR   = 2'd1,
        LOGW_INIT   = 2'd2,
        LOGW_CLEAR  = 2'd3
    } logword_e;

    typedef struct packed {
        logic              flag;
        logic              write;
        logic [WORD_W-1:0] addr;
        logic [INIT_W-1:0] init;
    } errlog_t;
endpackage

// File: rtl/fw_region_match.sv
module fw_region_match
    import fw_guard_pkg::*;
#(
    parameter int IDX = 1
) (
    input  logic [WORD_W-1:0]  amatch,
    input  logic [WORD_W-1:0]  addr,
    input  logic [SPACE_W-1:0] space,
    output logic               hit,
    output logic [LVL_W-1:0]   level
);
    logic [SIZE_W-1:0]  size_f;
    logic [SHAMT_W-1:0] shamt;
    logic [WORD_W-1:0]  diff;
    logic               unused_bit8;

    assign size_f      = amatch[SIZE_MSB:SIZE_LSB];
    assign shamt       = SHAMT_W'(size_f) + SHAMT_W'(KB_SHIFT);
    assign diff        = addr ^ {amatch[WORD_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
    assign unused_bit8 = amatch[8];

    // region span is 2^S KB: every bit at or above S+10 must agree with base
    assign hit = (size_f != '0) && ((diff >> shamt) == '0)
              && (space == amatch[SPACE_W-1:0]);

    generate
        if (IDX == 1) begin : g_fixed_top
            assign level = LVL_W'(TOP_LVL);
        end else begin : g_bit_level
            logic unused_lvl;
            assign unused_lvl = 1'b0;
            assign level = LVL_W'(amatch[LVL_BIT]) + LVL_W'(1);
        end
    endgenerate
endmodule

// File: rtl/fw_prio_pick.sv
module fw_prio_pick
    import fw_guard_pkg::*;
#(
    parameter int NREG  = 8,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic [NREG-1:0]            hit_v,
    input  logic [NREG-1:0][LVL_W-1:0] lvl_v,
    output logic [IDX_W-1:0]           win
);
    logic [LVL_W-1:0] best_lvl;

    // region 0 always covers, so it seeds the search; ">=" hands ties upward
    always_comb begin
        win      = '0;
        best_lvl = lvl_v[0];
        for (int r = 1; r < NREG; r++) begin
            if (hit_v[r] && (lvl_v[r] >= best_lvl)) begin
                win      = IDX_W'(r);
                best_lvl = lvl_v[r];
            end
        end
    end
endmodule

// File: rtl/fw_err_log.sv
module fw_err_log
    import fw_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deny_evt,
    input  logic              clr,
    input  logic [WORD_W-1:0] evt_addr,
    input  logic [INIT_W-1:0] evt_init,
    input  logic              evt_write,
    output errlog_t           log_q
);
    errlog_t log_d;

    always_comb begin
        log_d = log_q;
        if (deny_evt && (!log_q.flag || clr)) begin
            log_d.flag  = 1'b1;
            log_d.write = evt_write;
            log_d.addr  = evt_addr;
            log_d.init  = evt_init;
        end else if (clr) begin
            log_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) log_q <= '0;
        else        log_q <= log_d;
    end

    // R8: a held log survives unless cleared
    a_r8_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        log_q.flag && !clr |=> log_q.flag);

    // R8: a held log keeps the first offending address
    a_r8_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
        log_q.flag && !clr |=> $stable(log_q.addr));

    // R9: a clear with no competing denial empties the log
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !deny_evt |=> !log_q.flag);
endmodule

// File: rtl/fw_region_guard.sv
module fw_region_guard
    import fw_guard_pkg::*;
#(
    parameter int NREG = 8,
    localparam int IDX_W  = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int CFG_AW = $clog2((NREG + 1) * 4)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic [WORD_W-1:0]  acc_addr,
    input  logic [SPACE_W-1:0] acc_space,
    input  logic [INIT_W-1:0]  acc_init,
    input  logic               acc_write,
    input  logic               cfg_wr,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [WORD_W-1:0]  cfg_wdata,
    output logic [WORD_W-1:0]  cfg_rdata,
    output logic               dec_valid,
    output logic               dec_allow,
    output logic [IDX_W-1:0]   dec_region,
    output logic               err_flag
);
    localparam int GRP_W = CFG_AW - 2;

    typedef struct packed {
        region_t [NREG-1:0] regs;
        logic               dec_valid;
        logic               dec_allow;
        logic [IDX_W-1:0]   dec_region;
    } state_t;

    state_t st_d, st_q;

    logic [NREG-1:0]            hit_v;
    logic [NREG-1:0][LVL_W-1:0] lvl_v;
    logic [IDX_W-1:0]           win;
    region_t                    win_reg;
    logic                       allow_c;
    logic [GRP_W-1:0]           grp;
    field_e                     fld;
    logic                       grp_is_log;
    logic                       clr;
    errlog_t                    log_q;

    assign grp        = cfg_addr[CFG_AW-1:2];
    assign fld        = field_e'(cfg_addr[1:0]);
    assign grp_is_log = (int'(grp) == NREG);
    assign clr        = cfg_wr && grp_is_log && (logword_e'(cfg_addr[1:0]) == LOGW_CLEAR)
                     && cfg_wdata[0];

    // region 0: catch-all at level 0, no decoding
    assign hit_v[0] = 1'b1;
    assign lvl_v[0] = '0;

    generate
        for (genvar r = 1; r < NREG; r++) begin : g_match
            fw_region_match #(.IDX(r)) u_match (
                .amatch (st_q.regs[r].amatch),
                .addr   (acc_addr),
                .space  (acc_space),
                .hit    (hit_v[r]),
                .level  (lvl_v[r])
            );
        end
    endgenerate

    fw_prio_pick #(.NREG(NREG)) u_pick (
        .hit_v (hit_v),
        .lvl_v (lvl_v),
        .win   (win)
    );

    assign win_reg = st_q.regs[win];
    assign allow_c = win_reg.info[acc_init]
                  && (acc_write ? win_reg.wr[acc_init] : win_reg.rd[acc_init]);

    fw_err_log u_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .deny_evt  (acc_valid && !allow_c),
        .clr       (clr),
        .evt_addr  (acc_addr),
        .evt_init  (acc_init),
        .evt_write (acc_write),
        .log_q     (log_q)
    );

    always_comb begin
        st_d            = st_q;
        st_d.dec_valid  = acc_valid;
        st_d.dec_allow  = acc_valid && allow_c;
        st_d.dec_region = acc_valid ? win : '0;
        for (int r = 0; r < NREG; r++) begin
            if (cfg_wr && (int'(grp) == r)) begin
                case (fld)
                    FLD_INFO:   st_d.regs[r].info = cfg_wdata[MASK_W-1:0];
                    FLD_RD:     st_d.regs[r].rd   = cfg_wdata[MASK_W-1:0];
                    FLD_WR:     st_d.regs[r].wr   = cfg_wdata[MASK_W-1:0];
                    FLD_AMATCH: if (r != 0) st_d.regs[r].amatch = cfg_wdata;
                    default:    ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int r = 0; r < NREG; r++) begin
                st_q.regs[r].info <= '1;
                st_q.regs[r].rd   <= '1;
                st_q.regs[r].wr   <= '1;
            end
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (grp_is_log) begin
            case (logword_e'(cfg_addr[1:0]))
                LOGW_STATUS: cfg_rdata = {{(WORD_W-2){1'b0}}, log_q.write, log_q.flag};
                LOGW_ADDR:   cfg_rdata = log_q.addr;
                LOGW_INIT:   cfg_rdata = WORD_W'(log_q.init);
                default:     cfg_rdata = '0;
            endcase
        end else begin
            for (int r = 0; r < NREG; r++) begin
                if (int'(grp) == r) begin
                    case (fld)
                        FLD_INFO:   cfg_rdata = WORD_W'(st_q.regs[r].info);
                        FLD_RD:     cfg_rdata = WORD_W'(st_q.regs[r].rd);
                        FLD_WR:     cfg_rdata = WORD_W'(st_q.regs[r].wr);
                        FLD_AMATCH: cfg_rdata = st_q.regs[r].amatch;
                        default:    cfg_rdata = '0;
                    endcase
                end
            end
        end
    end

    assign dec_valid  = st_q.dec_valid;
    assign dec_allow  = st_q.dec_allow;
    assign dec_region = st_q.dec_region;
    assign err_flag   = log_q.flag;

    // R6/R8: every reported denial is already in the log
    a_r6_deny_logged: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && !dec_allow |-> err_flag);

    // R3: a region with size 0 never wins
    a_r3_disabled_loses: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && (win != '0) |-> (win_reg.amatch[SIZE_MSB:SIZE_LSB] != '0));

    // R5: the chosen region actually covers the access
    a_r5_winner_covers: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> hit_v[win]);

    generate
        for (genvar r = 1; r < NREG; r++) begin : g_lvl_chk
            // R5: no covering region outranks the winner
            a_r5_max_level: assert property (@(posedge clk) disable iff (!rst_n)
                acc_valid && hit_v[r] |-> (lvl_v[r] <= lvl_v[win]));
        end
    endgenerate
endmodule

// File: tb/fw_region_guard_bench.sv
module fw_region_guard_bench;
    localparam int NREG = 8;
    localparam int LOGB = NREG * 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid, acc_write, cfg_wr;
    logic [31:0] acc_addr, cfg_wdata, cfg_rdata;
    logic [2:0]  acc_space;
    logic [3:0]  acc_init;
    logic [5:0]  cfg_addr;
    logic        dec_valid, dec_allow, err_flag;
    logic [2:0]  dec_region;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    logic [15:0] m_info [NREG];
    logic [15:0] m_rd   [NREG];
    logic [15:0] m_wr   [NREG];
    logic [31:0] m_am   [NREG];
    bit          m_flag, m_write;
    logic [31:0] m_addr;
    logic [3:0]  m_init;

    fw_region_guard #(.NREG(NREG)) u_fw_region_guard (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_space(acc_space), .acc_init(acc_init), .acc_write(acc_write),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .dec_valid(dec_valid), .dec_allow(dec_allow),
        .dec_region(dec_region), .err_flag(err_flag)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int exp_win(input logic [31:0] a, input logic [2:0] s);
        int best = 0;
        int bl = 0;
        for (int r = 1; r < NREG; r++) begin
            int sz = int'(m_am[r][7:3]);
            int lv = (r == 1) ? 3 : int'(m_am[r][9]) + 1;
            logic [31:0] d = a ^ {m_am[r][31:10], 10'b0};
            if (sz != 0 && s == m_am[r][2:0] && (d >> (sz + 10)) == 0 && lv >= bl) begin
                best = r;
                bl = lv;
            end
        end
        return best;
    endfunction

    function automatic bit exp_allow(input int w, input logic [3:0] i, input bit wr);
        return m_info[w][i] && (wr ? m_wr[w][i] : m_rd[w][i]);
    endfunction

    function automatic void model_write(input int idx, input logic [31:0] d);
        int g = idx / 4;
        int f = idx % 4;
        if (g < NREG) begin
            if (f == 0) m_info[g] = d[15:0];
            if (f == 1) m_rd[g] = d[15:0];
            if (f == 2) m_wr[g] = d[15:0];
            if (f == 3 && g != 0) m_am[g] = d;
        end else if (g == NREG && f == 3 && d[0]) begin
            m_flag = 0; m_write = 0; m_addr = '0; m_init = '0;
        end
    endfunction

    function automatic void model_deny(input logic [31:0] a, input logic [3:0] i,
                                       input bit wr, input bit clr_now);
        if (!m_flag || clr_now) begin
            m_flag = 1; m_addr = a; m_init = i; m_write = wr;
        end
    endfunction

    task automatic wr_reg(input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1; cfg_addr = 6'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 0;
        model_write(idx, d);
    endtask

    task automatic rd_check(input int idx, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = 6'(idx);
        #1;
        check(cfg_rdata === exp, tag, cfg_rdata, exp);
    endtask

    task automatic access(input logic [31:0] a, input logic [2:0] s, input logic [3:0] i,
                          input bit wr, input string tag);
        int ew = exp_win(a, s);
        bit ea = exp_allow(ew, i, wr);
        @(negedge clk);
        acc_valid = 1; acc_addr = a; acc_space = s; acc_init = i; acc_write = wr;
        @(negedge clk);
        acc_valid = 0;
        check(dec_valid === 1'b1, {tag, " R7 valid"}, 32'(dec_valid), 1);
        check(dec_allow === ea, {tag, " R6 allow"}, 32'(dec_allow), 32'(ea));
        check(dec_region === 3'(ew), {tag, " R5 region"}, 32'(dec_region), 32'(ew));
        if (!ea) model_deny(a, i, wr, 0);
    endtask

    task automatic log_check(input string tag);
        rd_check(LOGB + 0, {30'b0, m_write, m_flag}, {tag, " R10 status"});
        rd_check(LOGB + 1, m_addr, {tag, " R8 addr"});
        rd_check(LOGB + 2, 32'(m_init), {tag, " R8 init"});
    endtask

    function automatic logic [31:0] am(input logic [31:0] base, input bit hi,
                                       input int sz, input int sp);
        return {base[31:10], hi, 1'b0, 5'(sz), 3'(sp)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; acc_valid = 0; acc_addr = '0; acc_space = '0; acc_init = '0;
        acc_write = 0; cfg_wr = 0; cfg_addr = '0; cfg_wdata = '0;
        for (int r = 0; r < NREG; r++) begin
            m_info[r] = '1; m_rd[r] = '1; m_wr[r] = '1; m_am[r] = '0;
        end
        m_flag = 0; m_write = 0; m_addr = '0; m_init = '0;
        repeat (3) @(posedge clk);
        rst_n = 1;

        // R1: reset state
        @(negedge clk);
        check(dec_valid === 1'b0, "R1 dec_valid idle", 32'(dec_valid), 0);
        check(err_flag === 1'b0, "R1 err_flag", 32'(err_flag), 0);
        rd_check(3 * 4 + 1, 32'h0000_FFFF, "R1 read mask");
        rd_check(5 * 4 + 3, 32'h0, "R1 match word");
        log_check("R1 log");
        access(32'h1234_5678, 3'd5, 4'd9, 1, "R1 open default");

        // R2: region 0 match word ignores writes
        wr_reg(0 * 4 + 3, 32'hFFFF_FFFF);
        rd_check(0 * 4 + 3, 32'h0, "R2 region0 word");
        access(32'hFFFF_F000, 3'd7, 4'd3, 0, "R2 catch-all");

        // R3/R6: region 2, 4KB at 0x10000, space 1, CPU read denied
        wr_reg(2 * 4 + 1, 32'h0000_FFFD);
        wr_reg(2 * 4 + 3, am(32'h0001_0000, 0, 2, 1));
        access(32'h0001_0ABC, 3'd1, 4'd1, 0, "R6 cpu read denied");
        check(dec_region === 3'd2, "R3 inside window", 32'(dec_region), 2);
        access(32'h0001_0ABC, 3'd0, 4'd1, 0, "R3 other space");
        check(dec_region === 3'd0, "R3 space miss", 32'(dec_region), 0);
        access(32'h0001_1000, 3'd1, 4'd1, 0, "R3 past span");
        check(dec_region === 3'd0, "R3 span miss", 32'(dec_region), 0);
        access(32'h0001_0ABC, 3'd1, 4'd1, 1, "R6 cpu write ok");
        check(dec_allow === 1'b1, "R6 write mask", 32'(dec_allow), 1);
        log_check("R8 first");
        check(m_addr == 32'h0001_0ABC, "R8 model addr", m_addr, 32'h0001_0ABC);
        access(32'h0001_0004, 3'd1, 4'd1, 0, "R8 second deny");
        log_check("R8 kept");

        // R6: request-info mask gates both directions (USB host bit 9)
        wr_reg(2 * 4 + 0, 32'h0000_FDFF);
        access(32'h0001_0010, 3'd1, 4'd9, 1, "R6 info mask");
        check(dec_allow === 1'b0, "R6 info deny", 32'(dec_allow), 0);

        // R5: tie at level 1, higher index wins
        wr_reg(3 * 4 + 3, am(32'h0001_0000, 0, 2, 1));
        access(32'h0001_0100, 3'd1, 4'd1, 0, "R5 tie");
        check(dec_region === 3'd3, "R5 tie index", 32'(dec_region), 3);
        // R4: bit 9 lifts region 2 above region 3
        wr_reg(2 * 4 + 3, am(32'h0001_0000, 1, 2, 1));
        access(32'h0001_0100, 3'd1, 4'd4, 0, "R4 bit9");
        check(dec_region === 3'd2, "R4 level two", 32'(dec_region), 2);
        // R4: region 1 with bit 9 clear still tops at level 3
        wr_reg(1 * 4 + 3, am(32'h0001_0000, 0, 3, 1));
        access(32'h0001_0100, 3'd1, 4'd3, 0, "R4 region1");
        check(dec_region === 3'd1, "R4 region1 top", 32'(dec_region), 1);
        // R3: size 0 disables region 1
        wr_reg(1 * 4 + 3, am(32'h0001_0000, 0, 0, 1));
        access(32'h0001_0100, 3'd1, 4'd3, 0, "R3 disabled");
        check(dec_region === 3'd2, "R3 disabled loses", 32'(dec_region), 2);

        // R9: clear written as 0 does nothing, as 1 empties
        wr_reg(LOGB + 3, 32'h0000_0000);
        check(err_flag === 1'b1, "R9 clear zero", 32'(err_flag), 1);
        wr_reg(LOGB + 3, 32'h0000_0001);
        check(err_flag === 1'b0, "R9 clear one", 32'(err_flag), 0);
        log_check("R9 cleared");
        rd_check(LOGB + 3, 32'h0, "R10 clear reads 0");

        // R8/R9: held log, then clear and denial in one cycle
        access(32'h0001_0200, 3'd1, 4'd9, 0, "R8 refill");
        @(negedge clk);
        acc_valid = 1; acc_addr = 32'h0001_0300; acc_space = 3'd1; acc_init = 4'd9;
        acc_write = 1; cfg_wr = 1; cfg_addr = 6'(LOGB + 3); cfg_wdata = 32'h1;
        @(negedge clk);
        acc_valid = 0; cfg_wr = 0;
        model_deny(32'h0001_0300, 4'd9, 1, 1);
        log_check("R9 clear vs deny");

        // R7: a write in the access cycle does not affect that access
        wr_reg(0 * 4 + 1, 32'h0);
        @(negedge clk);
        acc_valid = 1; acc_addr = 32'h0800_0000; acc_space = 3'd0; acc_init = 4'd1;
        acc_write = 0; cfg_wr = 1; cfg_addr = 6'(0 * 4 + 1); cfg_wdata = 32'hFFFF;
        @(negedge clk);
        acc_valid = 0; cfg_wr = 0;
        check(dec_allow === 1'b0, "R7 old config used", 32'(dec_allow), 0);
        model_deny(32'h0800_0000, 4'd1, 0, 0);
        model_write(0 * 4 + 1, 32'hFFFF);
        access(32'h0800_0000, 3'd0, 4'd1, 0, "R7 new config");
        check(dec_allow === 1'b1, "R7 next cycle", 32'(dec_allow), 1);

        // random phase
        for (int it = 0; it < 600; it++) begin
            if (it % 12 == 0) begin
                int r = 1 + int'($urandom % (NREG - 1));
                wr_reg(r * 4 + 0, $urandom | $urandom | $urandom);
                wr_reg(r * 4 + 1, $urandom | $urandom);
                wr_reg(r * 4 + 2, $urandom | $urandom);
                wr_reg(r * 4 + 3, am($urandom & 32'h0003_FC00, 1'($urandom),
                                     int'($urandom % 5), int'($urandom % 3)));
            end
            begin
                int r = 1 + int'($urandom % (NREG - 1));
                logic [31:0] a = {m_am[r][31:10], 10'b0} + ($urandom % 32'h4000);
                access(a, 3'($urandom % 3), 4'($urandom), 1'($urandom), "R5 random");
            end
            if (it % 60 == 59) begin
                log_check("R8 random");
                wr_reg(LOGB + 3, 32'h1);
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule